// File: doc/BRIEF.md
# Clamp-Mode Extreme-Current Turn-Off Arbiter

Several converter legs drive one shared output capacitor, each through its own inductor. When the output voltage clamps to a supply rail, no voltage is left across the inductors, so a slope-based forced turn-off condition becomes true for every leg in the same instant. If each leg acted on that shared condition, the legs would switch in step and the benefit of interleaving would be lost. This arbiter passes the forced turn-off to exactly one leg per event. The high-side turn-off goes to the leg with the largest sampled inductor current among the legs whose high-side switch is on. The low-side turn-off goes to the leg with the smallest current among the legs whose low-side switch is on. Repeated over many events, this pushes the legs apart. The spread settles only when the number of legs is odd.

The caller supplies the clamp-active flag and the two slope flags. The arbiter finds the maximum and minimum with a registered comparison tree. The tree depth is ceil(log2 N) cycles, and the enabling flags travel through a matching delay line. The block also computes the adjusted turn-off levels for the clamped side: twice the output current divided by the leg count, minus the threshold for the lower level and plus the threshold for the upper level.

Top module: `clamp_turnoff_arb`

## Requirements
- R1: When clamp and the non-positive-slope flag are high, `hs_grant_o` has a single bit set, at the leg with the largest signed current among legs with `hs_on_i` set.
- R2: When clamp and the non-negative-slope flag are high, `ls_grant_o` has a single bit set, at the leg with the smallest signed current among legs with `ls_on_i` set.
- R3: When currents are equal, the lowest leg index wins, for both the maximum and the minimum search.
- R4: Each grant vector has at most one bit set in every cycle.
- R5: While `clamp_i` is low, neither grant vector has any bit set.
- R6: A side is granted only when its own slope flag is high: `slope_nonpos_i` for the high side, `slope_nonneg_i` for the low side.
- R7: A leg whose switch on that side is off is never granted, even when it carries the extreme current. When no leg is on for a side, that side grants nothing.
- R8: A grant reflects the inputs sampled exactly ceil(log2 N) clock edges earlier. For the default N=3 this is 2 edges.
- R9: One edge after sampling, `clamp_lo_o` = trunc(2·iout/N) − ith and `clamp_hi_o` = trunc(2·iout/N) + ith. Both are signed, and the division rounds toward zero.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clamp_i | input | 1 | Output voltage is clamped |
| slope_nonpos_i | input | 1 | Inductor current slope is zero or negative |
| slope_nonneg_i | input | 1 | Inductor current slope is zero or positive |
| hs_on_i | input | N_LEGS | High-side switch on, one bit per leg |
| ls_on_i | input | N_LEGS | Low-side switch on, one bit per leg |
| leg_cur_i | input | N_LEGS×CUR_W | Signed sampled inductor current per leg |
| iout_i | input | CUR_W | Signed output current |
| ith_i | input | CUR_W | Signed threshold current |
| hs_grant_o | output | N_LEGS | One-hot high-side forced turn-off grant |
| ls_grant_o | output | N_LEGS | One-hot low-side forced turn-off grant |
| clamp_lo_o | output | CUR_W+2 | Adjusted lower turn-off level |
| clamp_hi_o | output | CUR_W+2 | Adjusted upper turn-off level |

## Verification
The assertions check on every cycle that:
- each grant vector is at most one-hot;
- a grant never appears unless the clamp and the matching slope flag were present, and the granted leg was in the required switch state, when the inputs were sampled one tree depth earlier;
- the two turn-off levels stay exactly twice the threshold apart;
- every output is zero during reset.

Only the bench scenarios can show which leg wins:
- the maximum and minimum choice;
- tie resolution toward the lowest index;
- the exact arrival cycle of a changed pattern;
- the signed rounding of the level arithmetic.

// File: rtl/clamp_arb_pkg.sv
package clamp_arb_pkg;

    // Number of registered comparison levels for n legs (at least one).
    function automatic int tree_depth(input int n);
        int d;
        d = 1;
        while ((1 << d) < n) d++;
        return d;
    endfunction

    // Width of a leg index for n legs (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic {
        SEEK_MIN = 1'b0,
        SEEK_MAX = 1'b1
    } seek_e;

endpackage

// File: rtl/arb_extreme_tree.sv
module arb_extreme_tree
    import clamp_arb_pkg::*;
#(
    parameter int    N_LEGS = 3,
    parameter int    CUR_W  = 12,
    parameter seek_e SEEK   = SEEK_MAX
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LEGS-1:0]             cand_i,
    input  logic [N_LEGS-1:0][CUR_W-1:0]  cur_i,
    input  logic                          fire_i,
    output logic [N_LEGS-1:0]             grant_o
);
    localparam int DEPTH = tree_depth(N_LEGS);
    localparam int LEAVES = 1 << DEPTH;
    localparam int HALF = LEAVES / 2;
    localparam int IW = idx_width(N_LEGS);

    typedef struct packed {
        logic             vld;
        logic [IW-1:0]    idx;
        logic [CUR_W-1:0] val;
    } node_t;

    typedef struct packed {
        node_t [DEPTH:1][HALF-1:0] lvl;
        logic  [DEPTH-1:0]         fire;
    } state_t;

    state_t s_d, s_q;
    node_t [DEPTH-1:0][LEAVES-1:0] src;

    // Left operand always holds the lower leg index, so the right one
    // replaces it only on a strict win: ties resolve to the lower index.
    function automatic node_t pick(input node_t a, input node_t b);
        logic take_b;
        if (!b.vld) return a;
        if (!a.vld) return b;
        if (SEEK == SEEK_MAX) take_b = $signed(b.val) > $signed(a.val);
        else                  take_b = $signed(b.val) < $signed(a.val);
        return take_b ? b : a;
    endfunction

    always_comb begin
        src = '0;
        for (int i = 0; i < LEAVES; i++) begin
            if (i < N_LEGS) begin
                src[0][i].vld = cand_i[i];
                src[0][i].idx = IW'(i);
                src[0][i].val = cur_i[i];
            end
        end
        for (int k = 1; k < DEPTH; k++) begin
            for (int j = 0; j < HALF; j++) begin
                src[k][j] = s_q.lvl[k][j];
            end
        end
    end

    always_comb begin
        s_d = s_q;
        for (int k = 1; k <= DEPTH; k++) begin
            for (int j = 0; j < HALF; j++) begin
                s_d.lvl[k][j] = pick(src[k-1][2*j], src[k-1][2*j+1]);
            end
        end
        s_d.fire[0] = fire_i;
        for (int k = 1; k < DEPTH; k++) begin
            s_d.fire[k] = s_q.fire[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    node_t root;
    assign root = s_q.lvl[DEPTH][0];

    always_comb begin
        grant_o = '0;
        if (s_q.fire[DEPTH-1] && root.vld) begin
            grant_o[root.idx] = 1'b1;
        end
    end

endmodule

// File: rtl/clamp_level_calc.sv
module clamp_level_calc #(
    parameter int N_LEGS = 3,
    parameter int CUR_W  = 12,
    localparam int LW    = CUR_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [CUR_W-1:0] iout_i,
    input  logic signed [CUR_W-1:0] ith_i,
    output logic signed [LW-1:0]    lo_o,
    output logic signed [LW-1:0]    hi_o
);
    localparam logic signed [LW-1:0] LEGS_S = LW'(N_LEGS);

    typedef struct packed {
        logic signed [LW-1:0] lo;
        logic signed [LW-1:0] hi;
    } lvl_t;

    lvl_t l_d, l_q;
    logic signed [LW-1:0] twice, share, ith_x;

    always_comb begin
        twice = LW'(iout_i) <<< 1;
        share = twice / LEGS_S;
        ith_x = LW'(ith_i);
        l_d.lo = share - ith_x;
        l_d.hi = share + ith_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign lo_o = l_q.lo;
    assign hi_o = l_q.hi;

endmodule

// File: rtl/clamp_turnoff_arb.sv
module clamp_turnoff_arb
    import clamp_arb_pkg::*;
#(
    parameter int N_LEGS = 3,
    parameter int CUR_W  = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clamp_i,
    input  logic                            slope_nonpos_i,
    input  logic                            slope_nonneg_i,
    input  logic [N_LEGS-1:0]               hs_on_i,
    input  logic [N_LEGS-1:0]               ls_on_i,
    input  logic [N_LEGS-1:0][CUR_W-1:0]    leg_cur_i,
    input  logic signed [CUR_W-1:0]         iout_i,
    input  logic signed [CUR_W-1:0]         ith_i,
    output logic [N_LEGS-1:0]               hs_grant_o,
    output logic [N_LEGS-1:0]               ls_grant_o,
    output logic signed [CUR_W+1:0]         clamp_lo_o,
    output logic signed [CUR_W+1:0]         clamp_hi_o
);
    logic hs_fire, ls_fire;

    always_comb begin
        hs_fire = clamp_i && slope_nonpos_i;
        ls_fire = clamp_i && slope_nonneg_i;
    end

    arb_extreme_tree #(.N_LEGS(N_LEGS), .CUR_W(CUR_W), .SEEK(SEEK_MAX)) u_hs_tree (
        .clk(clk), .rst_n(rst_n), .cand_i(hs_on_i), .cur_i(leg_cur_i),
        .fire_i(hs_fire), .grant_o(hs_grant_o)
    );

    arb_extreme_tree #(.N_LEGS(N_LEGS), .CUR_W(CUR_W), .SEEK(SEEK_MIN)) u_ls_tree (
        .clk(clk), .rst_n(rst_n), .cand_i(ls_on_i), .cur_i(leg_cur_i),
        .fire_i(ls_fire), .grant_o(ls_grant_o)
    );

    clamp_level_calc #(.N_LEGS(N_LEGS), .CUR_W(CUR_W)) u_level (
        .clk(clk), .rst_n(rst_n), .iout_i(iout_i), .ith_i(ith_i),
        .lo_o(clamp_lo_o), .hi_o(clamp_hi_o)
    );

endmodule

// File: rtl/clamp_arb_chk.sv
module clamp_arb_chk
    import clamp_arb_pkg::*;
#(
    parameter int N_LEGS = 3,
    parameter int CUR_W  = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clamp_i,
    input logic                     slope_nonpos_i,
    input logic                     slope_nonneg_i,
    input logic [N_LEGS-1:0]        hs_on_i,
    input logic [N_LEGS-1:0]        ls_on_i,
    input logic signed [CUR_W-1:0]  ith_i,
    input logic [N_LEGS-1:0]        hs_grant_o,
    input logic [N_LEGS-1:0]        ls_grant_o,
    input logic signed [CUR_W+1:0]  clamp_lo_o,
    input logic signed [CUR_W+1:0]  clamp_hi_o
);
    localparam int DEPTH = tree_depth(N_LEGS);

    logic [DEPTH-1:0]             hs_fire_h, ls_fire_h;
    logic [DEPTH-1:0][N_LEGS-1:0] hs_mask_h, ls_mask_h;
    logic                         seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_fire_h <= '0;
            ls_fire_h <= '0;
            hs_mask_h <= '0;
            ls_mask_h <= '0;
            seen_q    <= 1'b0;
        end else begin
            seen_q <= 1'b1;
            hs_fire_h[0] <= clamp_i && slope_nonpos_i;
            ls_fire_h[0] <= clamp_i && slope_nonneg_i;
            hs_mask_h[0] <= hs_on_i;
            ls_mask_h[0] <= ls_on_i;
            for (int k = 1; k < DEPTH; k++) begin
                hs_fire_h[k] <= hs_fire_h[k-1];
                ls_fire_h[k] <= ls_fire_h[k-1];
                hs_mask_h[k] <= hs_mask_h[k-1];
                ls_mask_h[k] <= ls_mask_h[k-1];
            end
        end
    end

    // R4
    hs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_grant_o));
    // R4
    ls_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ls_grant_o));
    // R5 R6
    hs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs_grant_o) |-> hs_fire_h[DEPTH-1]);
    // R5 R6
    ls_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ls_grant_o) |-> ls_fire_h[DEPTH-1]);
    // R7
    hs_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_grant_o & ~hs_mask_h[DEPTH-1]) == '0);
    // R7
    ls_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_grant_o & ~ls_mask_h[DEPTH-1]) == '0);
    // R9
    level_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((clamp_hi_o - clamp_lo_o) == ((CUR_W+2)'($past(ith_i)) <<< 1)));

    // R10
    always @(posedge clk) begin
        if (!rst_n) begin
            rst_zero_chk: assert (hs_grant_o == '0 && ls_grant_o == '0 &&
                                  clamp_lo_o == '0 && clamp_hi_o == '0);
        end
    end

endmodule

bind clamp_turnoff_arb clamp_arb_chk #(.N_LEGS(N_LEGS), .CUR_W(CUR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clamp_i(clamp_i),
    .slope_nonpos_i(slope_nonpos_i), .slope_nonneg_i(slope_nonneg_i),
    .hs_on_i(hs_on_i), .ls_on_i(ls_on_i), .ith_i(ith_i),
    .hs_grant_o(hs_grant_o), .ls_grant_o(ls_grant_o),
    .clamp_lo_o(clamp_lo_o), .clamp_hi_o(clamp_hi_o)
);

// File: tb/tb_clamp_turnoff_arb.sv
`timescale 1ns/1ps
module tb_clamp_turnoff_arb;
    localparam int N = 3;
    localparam int W = 12;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clamp, snp, snn;
    logic [N-1:0] hs_on, ls_on;
    logic [N-1:0][W-1:0] cur;
    logic signed [W-1:0] iout, ith;
    logic [N-1:0] hs_g, ls_g;
    logic signed [W+1:0] lo, hi;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    clamp_turnoff_arb #(.N_LEGS(N), .CUR_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .clamp_i(clamp), .slope_nonpos_i(snp),
        .slope_nonneg_i(snn), .hs_on_i(hs_on), .ls_on_i(ls_on), .leg_cur_i(cur),
        .iout_i(iout), .ith_i(ith), .hs_grant_o(hs_g), .ls_grant_o(ls_g),
        .clamp_lo_o(lo), .clamp_hi_o(hi)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected winner: strict comparison keeps the lower index on ties.
    function automatic int exp_pick(input int c0, input int c1, input int c2,
                                    input logic [N-1:0] m, input bit seek_max);
        int c[N];
        int best;
        c[0] = c0; c[1] = c1; c[2] = c2;
        best = -1;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                if (best < 0) best = i;
                else if (seek_max ? (c[i] > c[best]) : (c[i] < c[best])) best = i;
            end
        end
        return (best < 0) ? 0 : (1 << best);
    endfunction

    task automatic drive(input bit cl, input bit np, input bit nn,
                         input logic [N-1:0] hm, input logic [N-1:0] lm,
                         input int c0, input int c1, input int c2);
        clamp = cl; snp = np; snn = nn; hs_on = hm; ls_on = lm;
        cur[0] = W'(c0); cur[1] = W'(c1); cur[2] = W'(c2);
    endtask

    task automatic settle();
        repeat (LAT) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_pair(input string req, input bit cl, input bit np, input bit nn,
                            input logic [N-1:0] hm, input logic [N-1:0] lm,
                            input int c0, input int c1, input int c2);
        drive(cl, np, nn, hm, lm, c0, c1, c2);
        settle();
        check({req, " hs"}, int'(hs_g), (cl && np) ? exp_pick(c0, c1, c2, hm, 1'b1) : 0);
        check({req, " ls"}, int'(ls_g), (cl && nn) ? exp_pick(c0, c1, c2, lm, 1'b0) : 0);
    endtask

    task automatic t_reset();
        check("R10 hs", int'(hs_g), 0);
        check("R10 ls", int'(ls_g), 0);
        check("R10 lo", int'(lo), 0);
        check("R10 hi", int'(hi), 0);
    endtask

    task automatic t_max_min();
        run_pair("R1 R2 basic", 1, 1, 1, 3'b111, 3'b111, 100, 300, -50);
        run_pair("R1 R2 neg", 1, 1, 1, 3'b111, 3'b111, -200, -10, -900);
        run_pair("R1 R2 top", 1, 1, 1, 3'b111, 3'b111, 2047, -2048, 5);
    endtask

    task automatic t_ties();
        run_pair("R3 all equal", 1, 1, 1, 3'b111, 3'b111, 40, 40, 40);
        run_pair("R3 upper tie", 1, 1, 1, 3'b111, 3'b111, 10, 90, 90);
        run_pair("R3 lower tie", 1, 1, 1, 3'b111, 3'b111, 90, -5, -5);
    endtask

    task automatic t_gating();
        run_pair("R5 clamp low", 0, 1, 1, 3'b111, 3'b111, 1, 2, 3);
        run_pair("R6 hs only", 1, 1, 0, 3'b111, 3'b111, 1, 2, 3);
        run_pair("R6 ls only", 1, 0, 1, 3'b111, 3'b111, 1, 2, 3);
    endtask

    task automatic t_state();
        run_pair("R7 masked extreme", 1, 1, 1, 3'b011, 3'b110, 5, 9, 99);
        run_pair("R7 single", 1, 1, 1, 3'b100, 3'b001, 700, 0, -700);
        run_pair("R7 none on", 1, 1, 1, 3'b000, 3'b000, 3, 2, 1);
    endtask

    task automatic t_latency();
        drive(1, 1, 1, 3'b111, 3'b111, 10, 20, 30);
        settle();
        drive(1, 1, 1, 3'b111, 3'b111, 30, 20, 10);
        @(posedge clk); @(negedge clk);
        check("R8 edge1 hs old", int'(hs_g), 3'b100);
        check("R8 edge1 ls old", int'(ls_g), 3'b001);
        @(posedge clk); @(negedge clk);
        check("R8 edge2 hs new", int'(hs_g), 3'b001);
        check("R8 edge2 ls new", int'(ls_g), 3'b100);
    endtask

    task automatic t_levels(input int io, input int th);
        int share;
        iout = W'(io); ith = W'(th);
        @(posedge clk); @(negedge clk);
        share = (2 * io) / N;
        check("R9 lo", int'(lo), share - th);
        check("R9 hi", int'(hi), share + th);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        drive(0, 0, 0, '0, '0, 0, 0, 0);
        iout = '0; ith = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_max_min();
        t_ties();
        t_gating();
        t_state();
        t_latency();
        t_levels(100, 20);
        t_levels(-100, 20);
        t_levels(-2048, 2047);
        t_levels(7, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule